// File: doc/BRIEF.md
# SPI Flash Programmed Command Engine

This block is an SPI master that runs a single flash command each time software asks for one. Software fills in a command register and an address register. For writes it also loads a 64-byte data buffer. It then sets a go bit. The command register holds the opcode, a two-bit command kind, a data byte count, an atomic flag and a prefix opcode. The command kind says whether an address phase is sent and whether the data phase writes or reads. The engine drives the SPI pins in mode 0. The clock is the system clock divided by a programmable amount. Read data lands in the buffer. A sticky done flag reports the end of the cycle.

In atomic mode the engine first sends the prefix opcode in its own chip-select frame, for example a write-enable. Then it sends the command frame. Then it reads the flash status register until the device reports idle. No other requester gets the pins until the whole sequence ends. The engine shares the pins with a direct memory-read path through a request/grant pair. If a direct read holds the pins, a go request waits until that read is over. Register writes that arrive while a cycle is pending or running are refused and raise a sticky error flag.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset both chip selects are high, SCLK is low, and every status bit reads 0.
- R2: SPI mode 0. SCLK is low whenever no chip select is active. Each SCLK high phase lasts exactly DIV+1 system clocks, where DIV is register 2 bits [7:0]. Bytes go out MSB first. MOSI is stable while SCLK is high. MISO is sampled on the rising edge.
- R3: Address register bit 24 picks the chip select for every command, including commands with no address phase: 0 drives `spi_cs_n[0]` low, 1 drives `spi_cs_n[1]` low. At most one chip select is low at a time, and it stays the same for the whole frame.
- R4: A command frame carries the opcode, then address bits [23:0] as three bytes MSB first when the command kind bit 1 is set, then exactly COUNT data bytes. The command kind is command register bits [25:24], COUNT is bits [22:16], and the opcode is bits [7:0]. When kind bit 0 is 1, the data bytes come from the buffer. When it is 0, the engine sends 0x00 and stores each received byte into the buffer. Buffer byte i sits in data word i/4 (register 16+i/4), bits [8*(i%4)+7 : 8*(i%4)].
- R5: When the atomic flag (command register bit 28) is set, the prefix opcode (bits [15:8]) goes out alone in one frame. The command frame follows. Then come frames of 0x05 plus one read byte, repeated until bit 0 of the read byte is 0. The engine does not check which opcode it runs atomically.
- R6: Between two frames of a cycle, chip select stays high for at least 2*(DIV+1) system clocks.
- R7: `dr_gnt` equals `dr_req` while no cycle is active and is 0 while one is. A go accepted while `dr_req` is high waits, with status bit 3 (pending) set and no chip select asserted, until `dr_req` falls.
- R8: While a cycle is pending or running (status bit 2), writes to the command register, address register or data words leave them and the running frames unchanged, and set FCERR (status bit 1).
- R9: A go with COUNT equal to 0 or above 64 sets FCERR and starts no cycle.
- R10: Done (status bit 0) is set once the last frame and its closing gap have ended. Writing 1 to status bit 0 or bit 1 clears that bit. A go written while done is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index: 0 command, 1 address, 2 divider, 3 status, 16-31 data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| dr_req | input | 1 | Direct memory-read path asks for the pins |
| dr_gnt | output | 1 | Pins granted to the direct memory-read path |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
Two situations are hard to reach from the ports: a register write landing while frames are on the wire, and a go landing while the direct-read path holds the pins. The bench reaches the first by starting a long write cycle with a slow divider. It then writes the command, address and first data word while bytes are still going out. The scoreboard holds the frames computed from the original settings and rejects any byte that changed. A flash model in the bench answers the first two status polls with bit 0 set, so the polling loop runs three times. A direct-read request raised in the middle of that sequence must not be granted.

// File: rtl/sfs_pkg.sv
// Shared constants and state types for the SPI flash command engine.
package sfs_pkg;
    localparam int          CNT_W    = 7;      // width of the byte-count field
    localparam logic [7:0]  OP_RDSR  = 8'h05;  // flash status-read opcode
    localparam int          REG_CTRL = 0;
    localparam int          REG_ADDR = 1;
    localparam int          REG_DIV  = 2;
    localparam int          REG_STAT = 3;

    typedef enum logic [2:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT, SQ_GAP, SQ_FIN} seq_st_t;
    typedef enum logic [1:0] {FK_PRE, FK_CMD, FK_POLL} frame_t;
endpackage

// File: rtl/sfs_shifter.sv
// Mode-0 byte shifter: on start it shifts one byte out MSB first on MOSI and
// one byte in from MISO. SCLK toggles every DIV+1 clocks.
// Assumes start is only raised while the shifter is idle and DIV is held.
module sfs_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    output logic             done,
    output logic [7:0]       rx,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       txs;
    logic             busy_q;

    // Divider, edge generation and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; txs <= '0; rx <= '0;
            busy_q <= 1'b0; sclk <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    txs    <= tx;
                    cnt    <= '0;
                    bitn   <= '0;
                end
            end else if (cnt == div) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        txs  <= {txs[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mosi = txs[7];
endmodule

// File: rtl/sfs_sequencer.sv
// Frame sequencer: builds the prefix, command and status-poll frames, drives
// the chip selects, holds the inter-frame gap and reports when a cycle is done.
// Assumes the command fields stay constant while it is active.
module sfs_sequencer import sfs_pkg::*; #(
    parameter int DIV_W  = 8,
    parameter int BIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [7:0]        opcode,
    input  logic [7:0]        prefix,
    input  logic [1:0]        optype,
    input  logic [CNT_W-1:0]  count,
    input  logic              atomic,
    input  logic [24:0]       addr,
    input  logic [DIV_W-1:0]  div,
    input  logic [7:0]        brd,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    output logic [1:0]        cs_n,
    output logic              active,
    output logic              fin,
    output logic [BIDX_W-1:0] bidx,
    output logic              bwe,
    output logic [7:0]        bwdata
);
    localparam int IW = CNT_W + 1;
    localparam int GW = DIV_W + 2;

    seq_st_t        st;
    frame_t         fk, nk;
    logic           more;
    logic [IW-1:0]  idx, hdr, last;
    logic [GW-1:0]  gcnt, glen;
    logic           dphase, in_frame;
    logic [7:0]     txb;

    // Frame geometry: header length, last byte index, gap length.
    always_comb begin
        hdr = optype[1] ? IW'(4) : IW'(1);
        case (fk)
            FK_PRE:  last = IW'(1);
            FK_POLL: last = IW'(2);
            default: last = hdr + IW'(count);
        endcase
        glen   = (GW'(div) + GW'(1)) << 1;
        dphase = (fk == FK_CMD) && (idx >= hdr);
    end

    // Byte to transmit for the current frame position.
    always_comb begin
        case (fk)
            FK_PRE:  txb = prefix;
            FK_POLL: txb = (idx == '0) ? OP_RDSR : 8'h00;
            default: begin
                if (idx == '0)   txb = opcode;
                else if (!dphase) begin
                    case (idx[1:0])
                        2'd1:    txb = addr[23:16];
                        2'd2:    txb = addr[15:8];
                        default: txb = addr[7:0];
                    endcase
                end
                else             txb = optype[0] ? brd : 8'h00;
            end
        endcase
    end

    // Sequence state machine over frames and gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_IDLE; fk <= FK_CMD; nk <= FK_CMD;
            more <= 1'b0; idx <= '0; gcnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (launch) begin
                    fk  <= atomic ? FK_PRE : FK_CMD;
                    idx <= '0;
                    st  <= SQ_LOAD;
                end
                SQ_LOAD: st <= SQ_WAIT;
                SQ_WAIT: if (sh_done) begin
                    if (idx + IW'(1) == last) begin
                        st   <= SQ_GAP;
                        gcnt <= '0;
                        case (fk)
                            FK_PRE:  begin nk <= FK_CMD;  more <= 1'b1;     end
                            FK_CMD:  begin nk <= FK_POLL; more <= atomic;   end
                            default: begin nk <= FK_POLL; more <= sh_rx[0]; end
                        endcase
                    end else begin
                        idx <= idx + IW'(1);
                        st  <= SQ_LOAD;
                    end
                end
                SQ_GAP: if (gcnt == glen - GW'(1)) begin
                    if (more) begin
                        fk  <= nk;
                        idx <= '0;
                        st  <= SQ_LOAD;
                    end else begin
                        st  <= SQ_FIN;
                    end
                end else begin
                    gcnt <= gcnt + GW'(1);
                end
                SQ_FIN:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Outputs toward the shifter, the buffer and the pins.
    always_comb begin
        in_frame = (st == SQ_LOAD) || (st == SQ_WAIT);
        cs_n     = in_frame ? (addr[24] ? 2'b01 : 2'b10) : 2'b11;
        active   = (st != SQ_IDLE);
        fin      = (st == SQ_FIN);
        sh_start = (st == SQ_LOAD);
        sh_tx    = txb;
        bidx     = BIDX_W'(idx - hdr);
        bwe      = (st == SQ_WAIT) && sh_done && dphase && !optype[0];
        bwdata   = sh_rx;
    end
endmodule

// File: rtl/sfs_regs.sv
// Register file: command, address, divider, status and data buffer. It
// accepts go, checks the byte count, holds go pending behind a direct read and
// refuses writes while busy. Assumes the data window is reg_addr MSB set.
module sfs_regs import sfs_pkg::*; #(
    parameter int BUF_BYTES = 64,
    parameter int BIDX_W    = 6,
    parameter int DIV_W     = 8,
    parameter int AW        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dr_req,
    input  logic              active,
    input  logic              fin,
    output logic              launch,
    output logic [7:0]        opcode,
    output logic [7:0]        prefix,
    output logic [1:0]        optype,
    output logic [CNT_W-1:0]  count,
    output logic              atomic,
    output logic [24:0]       addr_q,
    output logic [DIV_W-1:0]  div_q,
    input  logic [BIDX_W-1:0] bidx,
    output logic [7:0]        brd,
    input  logic              bwe,
    input  logic [7:0]        bwdata
);
    localparam int NW  = BUF_BYTES / 4;
    localparam int WIW = $clog2(NW);

    logic [31:0]      bufw [NW];
    logic             done_q, fcerr_q, pend_q, busy;
    logic             sel_ctrl, sel_addr, sel_div, sel_stat, sel_data, go_try, bad_cnt;
    logic [CNT_W-1:0] wcnt;

    // Write decode and go qualification.
    always_comb begin
        busy     = pend_q | active;
        sel_ctrl = reg_we && (reg_addr == AW'(REG_CTRL));
        sel_addr = reg_we && (reg_addr == AW'(REG_ADDR));
        sel_div  = reg_we && (reg_addr == AW'(REG_DIV));
        sel_stat = reg_we && (reg_addr == AW'(REG_STAT));
        sel_data = reg_we && reg_addr[AW-1];
        wcnt     = reg_wdata[16 +: CNT_W];
        bad_cnt  = (wcnt == '0) || (wcnt > CNT_W'(BUF_BYTES));
        go_try   = sel_ctrl && !busy && reg_wdata[31] && !done_q;
        launch   = pend_q && !active && !dr_req;
    end

    // Command, address, divider and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0; prefix <= '0; optype <= '0; count <= '0; atomic <= 1'b0;
            addr_q <= '0; div_q <= '0; done_q <= 1'b0; fcerr_q <= 1'b0; pend_q <= 1'b0;
        end else begin
            if (sel_ctrl && !busy) begin
                opcode <= reg_wdata[7:0];
                prefix <= reg_wdata[15:8];
                count  <= wcnt;
                optype <= reg_wdata[25:24];
                atomic <= reg_wdata[28];
            end
            if (sel_addr && !busy) addr_q <= reg_wdata[24:0];
            if (sel_div && !busy)  div_q  <= reg_wdata[DIV_W-1:0];
            if (launch)                    pend_q <= 1'b0;
            else if (go_try && !bad_cnt)   pend_q <= 1'b1;
            if (((sel_ctrl || sel_addr || sel_data) && busy) || (go_try && bad_cnt))
                fcerr_q <= 1'b1;
            else if (sel_stat && reg_wdata[1])
                fcerr_q <= 1'b0;
            if (fin)                           done_q <= 1'b1;
            else if (sel_stat && reg_wdata[0]) done_q <= 1'b0;
        end
    end

    // Data buffer: bus word writes when idle, engine byte writes when active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) bufw[i] <= '0;
        end else if (sel_data && !busy) begin
            bufw[reg_addr[WIW-1:0]] <= reg_wdata;
        end else if (bwe) begin
            bufw[bidx[BIDX_W-1:2]][8*bidx[1:0] +: 8] <= bwdata;
        end
    end

    assign brd = bufw[bidx[BIDX_W-1:2]][8*bidx[1:0] +: 8];

    // Register read mux.
    always_comb begin
        if (reg_addr[AW-1]) reg_rdata = bufw[reg_addr[WIW-1:0]];
        else begin
            case (reg_addr)
                AW'(REG_CTRL): reg_rdata = {3'b0, atomic, 2'b0, optype, 1'b0, count, prefix, opcode};
                AW'(REG_ADDR): reg_rdata = {7'b0, addr_q};
                AW'(REG_DIV):  reg_rdata = 32'(div_q);
                AW'(REG_STAT): reg_rdata = {28'b0, pend_q, busy, fcerr_q, done_q};
                default:       reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_flash_seq.sv
// Top of the SPI flash command engine: register file, frame sequencer and
// byte shifter, plus the grant to the direct memory-read path.
// Assumes dr_req stays high for as long as the direct read uses the pins.
module spi_flash_seq import sfs_pkg::*; #(
    parameter int BUF_BYTES = 64,
    parameter int DIV_W     = 8,
    parameter int AW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          dr_req,
    output logic          dr_gnt,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic [1:0]    spi_cs_n
);
    localparam int BIDX_W = $clog2(BUF_BYTES);

    logic              launch, seq_active, fin, sh_start, sh_done, bwe, atomic;
    logic [7:0]        opcode, prefix, sh_tx, sh_rx, brd, bwdata;
    logic [1:0]        optype;
    logic [CNT_W-1:0]  count;
    logic [24:0]       addr_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIDX_W-1:0] bidx;

    sfs_regs #(.BUF_BYTES(BUF_BYTES), .BIDX_W(BIDX_W), .DIV_W(DIV_W), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dr_req(dr_req),
        .active(seq_active), .fin(fin), .launch(launch), .opcode(opcode),
        .prefix(prefix), .optype(optype), .count(count), .atomic(atomic),
        .addr_q(addr_q), .div_q(div_q), .bidx(bidx), .brd(brd),
        .bwe(bwe), .bwdata(bwdata)
    );

    sfs_sequencer #(.DIV_W(DIV_W), .BIDX_W(BIDX_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .opcode(opcode),
        .prefix(prefix), .optype(optype), .count(count), .atomic(atomic),
        .addr(addr_q), .div(div_q), .brd(brd), .sh_done(sh_done),
        .sh_rx(sh_rx), .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n),
        .active(seq_active), .fin(fin), .bidx(bidx), .bwe(bwe), .bwdata(bwdata)
    );

    sfs_shifter #(.DIV_W(DIV_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .div(div_q), .start(sh_start), .tx(sh_tx),
        .done(sh_done), .rx(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi),
        .miso(spi_miso)
    );

    // The direct-read path owns the pins only while no cycle is active.
    assign dr_gnt = dr_req && !seq_active;
endmodule

// File: rtl/sfs_checker.sv
// Protocol checker for spi_flash_seq, attached through bind.
module sfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       dr_req,
    input logic       dr_gnt,
    input logic       launch
);
    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R3
    AST_CS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != 2'b11 && $past(cs_n) != 2'b11) |-> $stable(cs_n)); // R3
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 2'b11) |-> !sclk); // R2
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R2
    AST_NO_GNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != 2'b11) |-> !dr_gnt); // R7
    AST_LAUNCH_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!dr_req && cs_n == 2'b11)); // R7
endmodule

bind spi_flash_seq sfs_checker i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .dr_req(dr_req), .dr_gnt(dr_gnt), .launch(launch)
);

// File: tb/test_spi_flash_seq.sv
// Scoreboard bench: tasks queue the expected frame bytes, a pin monitor with a
// flash model pops and compares them, and register reads check status/data.
module test_spi_flash_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, dr_req = 1'b0, spi_miso = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dr_gnt, spi_sclk, spi_mosi;
    logic [1:0]  spi_cs_n;

    int checks = 0, failures = 0, cur_div = 0, busy_left = 0;
    bit finished = 0;
    logic [9:0] exp_q[$];

    spi_flash_seq i_spi_flash_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dr_req(dr_req),
        .dr_gnt(dr_gnt), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [7:0] op, input logic [7:0] pre,
            input int cnt, input logic [1:0] typ, input bit atom, input bit go);
        return {go, 2'b0, atom, 2'b0, typ, 1'b0, 7'(cnt), pre, op};
    endfunction

    task automatic exp_b(input bit cs, input logic [7:0] b); exp_q.push_back({1'b0, cs, b}); endtask
    task automatic exp_e(input bit cs); exp_q.push_back({1'b1, cs, 8'h00}); endtask

    task automatic pop_cmp(input logic [9:0] got);
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected frame item", int'(got), 0);
        else begin
            logic [9:0] e = exp_q.pop_front();
            chk(e == got, "R4 frame item", int'(got), int'(e));
        end
    endtask

    task automatic wait_done();
        logic [31:0] s = '0;
        for (int n = 0; n < 40000 && !s[0]; n++) rd(5'd3, s);
        chk(s[0] == 1'b1, "R10 done reached", int'(s), 1);
    endtask

    // Pin monitor and flash model, sampled on the falling system clock edge.
    logic [1:0] pcs = 2'b11;
    logic       psclk = 1'b0, fsel = 1'b0;
    logic [7:0] shin = '0, outb = '0, first = '0;
    int hi_w = 0, gap_w = 0, bitc = 0, byte_k = 0;
    bit seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pcs == 2'b11 && spi_cs_n != 2'b11) begin
                if (seen) chk(gap_w >= 2*(cur_div+1), "R6 gap", gap_w, 2*(cur_div+1));
                seen = 1; fsel = (spi_cs_n == 2'b01); bitc = 0; byte_k = 0;
                outb = 8'h00; spi_miso = 1'b0;
            end
            if (spi_cs_n == 2'b11) begin
                if (pcs != 2'b11) begin pop_cmp({1'b1, fsel, 8'h00}); gap_w = 0; end
                gap_w++;
            end else begin
                if (!psclk && spi_sclk) begin
                    shin = {shin[6:0], spi_mosi}; bitc++; hi_w = 1;
                    if (bitc == 8) begin
                        if (byte_k == 0) first = shin;
                        pop_cmp({1'b0, fsel, shin});
                        bitc = 0; byte_k++;
                    end
                end else if (spi_sclk) hi_w++;
                if (psclk && !spi_sclk) begin
                    chk(hi_w == cur_div+1, "R2 sclk high width", hi_w, cur_div+1);
                    if (bitc == 0) begin
                        if (first == 8'h05 && byte_k == 1) begin
                            outb = (busy_left > 0) ? 8'h01 : 8'h00;
                            if (busy_left > 0) busy_left--;
                        end else outb = 8'h3C + 8'(byte_k);
                    end else outb = {outb[6:0], 1'b0};
                    spi_miso = outb[7];
                end
            end
            pcs = spi_cs_n; psclk = spi_sclk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk(spi_cs_n == 2'b11 && spi_sclk == 1'b0, "R1 pins", int'({spi_cs_n, spi_sclk}), 6);
        rd(5'd3, d); chk(d == 0, "R1 status", int'(d), 0);

        // R4/R3: write with address on cs0, divider 1
        cur_div = 1; wr(5'd2, 32'd1);
        wr(5'd16, 32'h44332211); wr(5'd17, 32'h88776655);
        wr(5'd1, 32'h0012345);
        exp_b(0, 8'h02); exp_b(0, 8'h01); exp_b(0, 8'h23); exp_b(0, 8'h45);
        exp_b(0, 8'h11); exp_b(0, 8'h22); exp_b(0, 8'h33); exp_e(0);
        wr(5'd0, mk_ctrl(8'h02, 8'h00, 3, 2'b11, 0, 1));
        wait_done();
        rd(5'd3, d); chk(d == 32'h1, "R10 done only", int'(d), 1);
        wr(5'd3, 32'h3); rd(5'd3, d); chk(d == 0, "R10 w1c", int'(d), 0);

        // R3/R4: read without address on cs1, three bytes into the buffer
        wr(5'd1, 32'h1000000);
        exp_b(1, 8'h9F); exp_b(1, 8'h00); exp_b(1, 8'h00); exp_b(1, 8'h00); exp_e(1);
        wr(5'd0, mk_ctrl(8'h9F, 8'h00, 3, 2'b00, 0, 1));
        wait_done(); wr(5'd3, 32'h1);
        rd(5'd16, d); chk(d == 32'h443F3E3D, "R4 read data no addr", int'(d), 32'h443F3E3D);

        // R4: read with address, divider 0, five bytes across two words
        cur_div = 0; wr(5'd2, 32'd0);
        wr(5'd1, 32'h00ABCDE);
        exp_b(0, 8'h0B); exp_b(0, 8'h0A); exp_b(0, 8'hBC); exp_b(0, 8'hDE);
        for (int i = 0; i < 5; i++) exp_b(0, 8'h00);
        exp_e(0);
        wr(5'd0, mk_ctrl(8'h0B, 8'h00, 5, 2'b10, 0, 1));
        wait_done(); wr(5'd3, 32'h1);
        rd(5'd16, d); chk(d == 32'h43424140, "R4 read word0", int'(d), 32'h43424140);
        rd(5'd17, d); chk(d == 32'h88776644, "R4 read word1", int'(d), 32'h88776644);

        // R5/R7: atomic prefix, command, three status polls; no grant inside
        wr(5'd16, 32'h000000A5); wr(5'd1, 32'h1000020); busy_left = 2;
        exp_b(1, 8'h06); exp_e(1);
        exp_b(1, 8'hD8); exp_b(1, 8'h00); exp_b(1, 8'h00); exp_b(1, 8'h20); exp_b(1, 8'hA5); exp_e(1);
        for (int p = 0; p < 3; p++) begin exp_b(1, 8'h05); exp_b(1, 8'h00); exp_e(1); end
        wr(5'd0, mk_ctrl(8'hD8, 8'h06, 1, 2'b11, 1, 1));
        repeat (30) @(negedge clk); dr_req = 1'b1;
        repeat (3) @(negedge clk); #1;
        chk(dr_gnt == 1'b0, "R7 no grant during atomic", int'(dr_gnt), 0);
        wait_done(); #1;
        chk(dr_gnt == 1'b1, "R7 grant when idle", int'(dr_gnt), 1);
        chk(exp_q.size() == 0, "R5 all polls seen", exp_q.size(), 0);
        wr(5'd3, 32'h1);

        // R7: go held pending behind an active direct read
        wr(5'd1, 32'h0000000);
        exp_b(0, 8'h9F); exp_b(0, 8'h00); exp_e(0);
        wr(5'd0, mk_ctrl(8'h9F, 8'h00, 1, 2'b00, 0, 1));
        repeat (40) @(negedge clk); #1;
        chk(spi_cs_n == 2'b11, "R7 pending no cs", int'(spi_cs_n), 3);
        rd(5'd3, d); chk(d == 32'hC, "R7 pending status", int'(d), 32'hC);
        dr_req = 1'b0;
        wait_done(); wr(5'd3, 32'h1);

        // R8: writes during a running write cycle are refused and flagged
        cur_div = 3; wr(5'd2, 32'd3);
        wr(5'd16, 32'hD4C3B2A1); wr(5'd1, 32'h0000010);
        exp_b(0, 8'h02); exp_b(0, 8'h00); exp_b(0, 8'h00); exp_b(0, 8'h10);
        exp_b(0, 8'hA1); exp_b(0, 8'hB2); exp_b(0, 8'hC3); exp_b(0, 8'hD4); exp_e(0);
        wr(5'd0, mk_ctrl(8'h02, 8'h00, 4, 2'b11, 0, 1));
        repeat (100) @(negedge clk);
        wr(5'd0, mk_ctrl(8'hAA, 8'h00, 2, 2'b00, 0, 1));
        wr(5'd1, 32'h1FFFFFF); wr(5'd16, 32'hDEADBEEF);
        rd(5'd3, d); chk(d[1] == 1'b1, "R8 fcerr set", int'(d), 32'h6);
        wait_done();
        rd(5'd1, d); chk(d == 32'h10, "R8 addr kept", int'(d), 32'h10);
        rd(5'd16, d); chk(d == 32'hD4C3B2A1, "R8 data kept", int'(d), 32'hD4C3B2A1);
        rd(5'd0, d); chk(d[7:0] == 8'h02, "R8 opcode kept", int'(d[7:0]), 2);
        wr(5'd3, 32'h3);

        // R9: bad byte counts raise fcerr and start nothing
        cur_div = 0; wr(5'd2, 32'd0);
        wr(5'd0, mk_ctrl(8'h03, 8'h00, 0, 2'b00, 0, 1));
        repeat (40) @(negedge clk);
        rd(5'd3, d); chk(d == 32'h2, "R9 count zero", int'(d), 2);
        wr(5'd3, 32'h2);
        wr(5'd0, mk_ctrl(8'h03, 8'h00, 65, 2'b00, 0, 1));
        repeat (40) @(negedge clk);
        rd(5'd3, d); chk(d == 32'h2, "R9 count 65", int'(d), 2);
        wr(5'd3, 32'h2);

        // R9/R4: the 64-byte boundary runs in full
        for (int w = 0; w < 16; w++)
            wr(5'(16 + w), {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        exp_b(0, 8'h32);
        for (int i = 0; i < 64; i++) exp_b(0, 8'(i));
        exp_e(0);
        wr(5'd0, mk_ctrl(8'h32, 8'h00, 64, 2'b01, 0, 1));
        wait_done();
        chk(exp_q.size() == 0, "R9 64 bytes sent", exp_q.size(), 0);

        // R10: go ignored while done is still set
        wr(5'd0, mk_ctrl(8'h9F, 8'h00, 1, 2'b00, 0, 1));
        repeat (60) @(negedge clk);
        rd(5'd3, d); chk(d == 32'h1, "R10 go ignored", int'(d), 1);
        chk(exp_q.size() == 0, "R10 no frames left", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule